// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block is a small datapath in which four general-purpose registers share a single bus. In every cycle exactly one word drives the bus. It is one of the general registers, chosen by a 2-bit source select, unless an override places the data register or an external literal on the bus instead. Any one general register can take the bus value at the next clock edge. It is chosen by a 2-bit destination code that goes through an enabled 2-to-4 decoder. A "source to bus, bus to destination" transfer therefore completes in one clock.

An address register and a data register connect the bus to a 16-word internal memory. The address register takes the low bits of the bus. The data register takes either the bus or the memory word at the current address. A memory write stores the data register into the word at the current address. Every register samples its inputs as they stood before the clock edge, so bus loads, address and data updates and a memory write can all happen in the same cycle without interfering.

The block has no state machine. Its sequencing is left to whatever drives its controls. The data register's next-value choice is the only enumerated decision: hold, take the bus, or take memory.

Top module: `rt_bus_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears all four general registers, the address register and the data register to zero at the clock edge.
- R2: With `lit_sel` and `dr_sel` low, `bus_q` shows general register number `src_sel`, where code 0 selects register 0 and code 3 selects register 3.
- R3: When `lit_sel` is 1, `bus_q` equals `bus_lit`. When `lit_sel` is 0 and `dr_sel` is 1, `bus_q` equals the data register. The literal has priority over the data register.
- R4: When `dst_en` is 1, the general register numbered `dst_sel` loads all 8 bits of the pre-edge bus value at the clock edge. The other three registers keep their values.
- R5: When `dst_en` is 0, no general register changes, whatever `dst_sel` and the bus carry.
- R6: A transfer from one general register to another completes in a single clock, and the source register keeps its value.
- R7: When `ar_ld` is 1, the address register loads `bus_q[3:0]` at the edge. Otherwise it holds its value.
- R8: When `mem_rd` is 1, the data register loads the memory word at the pre-edge address. Otherwise, when `dr_ld` is 1, it loads `bus_q`. Otherwise it holds its value. A memory read wins over a bus load.
- R9: When `mem_wr` is 1, the pre-edge data register is stored at the pre-edge address. This happens even if `ar_ld`, `dr_ld` or `dst_en` change those registers or a general register in the same cycle.
- R10: A memory word keeps its written value while other addresses are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | General register that drives the bus |
| lit_sel | input | 1 | Drive `bus_lit` onto the bus (highest priority) |
| dr_sel | input | 1 | Drive the data register onto the bus |
| bus_lit | input | 8 | External literal word |
| dst_en | input | 1 | Enable of the destination decoder |
| dst_sel | input | 2 | General register that loads from the bus |
| ar_ld | input | 1 | Load the address register from bus bits 3..0 |
| dr_ld | input | 1 | Load the data register from the bus |
| mem_rd | input | 1 | Load the data register from memory at the address register |
| mem_wr | input | 1 | Store the data register into memory at the address register |
| bus_q | output | 8 | Current bus value |
| ar_q | output | 4 | Address register |
| dr_q | output | 8 | Data register |

## Verification
Suppose a general register is corrupted, or loaded when its decode line should have stayed low. The fault stays hidden until that register is selected as the bus source, and then it shows on `bus_q` at once, with no latency. A wrong address or data register value shows on `ar_q` or `dr_q` one clock after the faulty edge. A wrong memory write is invisible until a later read of that address brings the word into the data register, one clock after the read is issued. The bench therefore reads back every register and memory word it has touched, and reads a second memory word to catch aliasing.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        DR_HOLD     = 2'd0,
        DR_FROM_BUS = 2'd1,
        DR_FROM_MEM = 2'd2
    } dr_src_e;

    function automatic dr_src_e dr_choose(input logic rd, input logic ld);
        if (rd)      return DR_FROM_MEM;
        else if (ld) return DR_FROM_BUS;
        else         return DR_HOLD;
    endfunction
endpackage

// File: rtl/rt_dest_dec.sv
module rt_dest_dec #(
    parameter int N  = 4,
    parameter int SW = 2
) (
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  ld
);
    for (genvar i = 0; i < N; i++) begin : g_line
        assign ld[i] = en && (sel == SW'(i));
    end
endmodule

// File: rtl/rt_reg_bank.sv
module rt_reg_bank #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  ld,
    input  logic [DW-1:0] din,
    input  logic [SW-1:0] rd_sel,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] q [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)        q[i] <= '0;
            else if (ld[i]) q[i] <= din;
        end
    end

    assign rd_data = q[rd_sel];
endmodule

// File: rtl/rt_bus_mux.sv
module rt_bus_mux #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] reg_word,
    input  logic [DW-1:0] dr_word,
    input  logic [DW-1:0] lit_word,
    input  logic          lit_sel,
    input  logic          dr_sel,
    output logic [DW-1:0] bus
);
    always_comb begin
        if (lit_sel)     bus = lit_word;
        else if (dr_sel) bus = dr_word;
        else             bus = reg_word;
    end
endmodule

// File: rtl/rt_word_mem.sv
module rt_word_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rt_bus_datapath.sv
module rt_bus_datapath #(
    parameter int DW   = 8,
    parameter int AW   = 4,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] src_sel,
    input  logic          lit_sel,
    input  logic          dr_sel,
    input  logic [DW-1:0] bus_lit,
    input  logic          dst_en,
    input  logic [SW-1:0] dst_sel,
    input  logic          ar_ld,
    input  logic          dr_ld,
    input  logic          mem_rd,
    input  logic          mem_wr,
    output logic [DW-1:0] bus_q,
    output logic [AW-1:0] ar_q,
    output logic [DW-1:0] dr_q
);
    import rt_pkg::*;

    logic [NREG-1:0] reg_ld;
    logic [DW-1:0]   reg_word;
    logic [DW-1:0]   mem_word;
    logic [DW-1:0]   bus;
    logic [AW-1:0]   ar_r;
    logic [DW-1:0]   dr_r;
    dr_src_e         dr_src;

    rt_dest_dec #(.N(NREG), .SW(SW)) u_dec (
        .en  (dst_en),
        .sel (dst_sel),
        .ld  (reg_ld)
    );

    rt_reg_bank #(.N(NREG), .DW(DW), .SW(SW)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ld      (reg_ld),
        .din     (bus),
        .rd_sel  (src_sel),
        .rd_data (reg_word)
    );

    rt_bus_mux #(.DW(DW)) u_mux (
        .reg_word (reg_word),
        .dr_word  (dr_r),
        .lit_word (bus_lit),
        .lit_sel  (lit_sel),
        .dr_sel   (dr_sel),
        .bus      (bus)
    );

    rt_word_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_wr),
        .addr  (ar_r),
        .wdata (dr_r),
        .rdata (mem_word)
    );

    always_ff @(posedge clk) begin
        if (rst)        ar_r <= '0;
        else if (ar_ld) ar_r <= bus[AW-1:0];
    end

    assign dr_src = dr_choose(mem_rd, dr_ld);

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_r <= '0;
        end else begin
            unique case (dr_src)
                DR_FROM_MEM: dr_r <= mem_word;
                DR_FROM_BUS: dr_r <= bus;
                default:     dr_r <= dr_r;
            endcase
        end
    end

    assign bus_q = bus;
    assign ar_q  = ar_r;
    assign dr_q  = dr_r;
endmodule

// File: rtl/rt_bus_datapath_chk.sv
module rt_bus_datapath_chk #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          lit_sel,
    input logic          dr_sel,
    input logic [DW-1:0] bus_lit,
    input logic          ar_ld,
    input logic          dr_ld,
    input logic          mem_rd,
    input logic [DW-1:0] bus_q,
    input logic [AW-1:0] ar_q,
    input logic [DW-1:0] dr_q
);
    assert_lit_on_bus_R3: assert property (@(posedge clk) disable iff (rst)
        lit_sel |-> bus_q == bus_lit);

    assert_dr_on_bus_R3: assert property (@(posedge clk) disable iff (rst)
        (!lit_sel && dr_sel) |-> bus_q == dr_q);

    assert_ar_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !ar_ld |=> $stable(ar_q));

    assert_ar_load_R7: assert property (@(posedge clk) disable iff (rst)
        ar_ld |=> ar_q == $past(bus_q[AW-1:0]));

    assert_dr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && !dr_ld) |=> $stable(dr_q));

    assert_dr_bus_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_rd && dr_ld) |=> dr_q == $past(bus_q));
endmodule

bind rt_bus_datapath rt_bus_datapath_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .lit_sel (lit_sel),
    .dr_sel  (dr_sel),
    .bus_lit (bus_lit),
    .ar_ld   (ar_ld),
    .dr_ld   (dr_ld),
    .mem_rd  (mem_rd),
    .bus_q   (bus_q),
    .ar_q    (ar_q),
    .dr_q    (dr_q)
);

// File: tb/tb_rt_bus_datapath.sv
module tb_rt_bus_datapath;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_sel, dst_sel;
    logic       lit_sel, dr_sel, dst_en, ar_ld, dr_ld, mem_rd, mem_wr;
    logic [7:0] bus_lit;
    logic [7:0] bus_q, dr_q;
    logic [3:0] ar_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_bus_datapath dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .lit_sel(lit_sel), .dr_sel(dr_sel),
        .bus_lit(bus_lit), .dst_en(dst_en), .dst_sel(dst_sel), .ar_ld(ar_ld),
        .dr_ld(dr_ld), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .bus_q(bus_q), .ar_q(ar_q), .dr_q(dr_q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        src_sel = 2'd0; dst_sel = 2'd0; lit_sel = 1'b0; dr_sel = 1'b0;
        bus_lit = 8'h00; dst_en = 1'b0; ar_ld = 1'b0; dr_ld = 1'b0;
        mem_rd = 1'b0; mem_wr = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic read_reg(input string req, input int k, input logic [7:0] exp);
        idle();
        src_sel = 2'(k);
        #1;
        check(req, bus_q, exp);
    endtask

    task automatic lit_to_reg(input int k, input logic [7:0] v);
        idle();
        lit_sel = 1'b1; bus_lit = v; dst_en = 1'b1; dst_sel = 2'(k);
        step();
    endtask

    task automatic t_reset();
        idle();
        rst = 1'b1;
        step();
        rst = 1'b0;
        for (int k = 0; k < 4; k++) read_reg("R1 reg", k, 8'h00);
        check("R1 ar", {4'h0, ar_q}, 8'h00);
        check("R1 dr", dr_q, 8'h00);
    endtask

    task automatic t_load_all();
        lit_to_reg(0, 8'h3C);
        lit_to_reg(1, 8'hA5);
        lit_to_reg(2, 8'h0F);
        lit_to_reg(3, 8'hF0);
        read_reg("R2 r0", 0, 8'h3C);
        read_reg("R2 r1", 1, 8'hA5);
        read_reg("R4 r2", 2, 8'h0F);
        read_reg("R4 r3", 3, 8'hF0);
    endtask

    task automatic t_disabled();
        idle();
        lit_sel = 1'b1; bus_lit = 8'hFF; dst_sel = 2'd2; dst_en = 1'b0;
        step();
        read_reg("R5 r0", 0, 8'h3C);
        read_reg("R5 r1", 1, 8'hA5);
        read_reg("R5 r2", 2, 8'h0F);
        read_reg("R5 r3", 3, 8'hF0);
    endtask

    task automatic t_reg_xfer();
        idle();
        src_sel = 2'd1; dst_en = 1'b1; dst_sel = 2'd2;
        step();
        read_reg("R6 dest", 2, 8'hA5);
        read_reg("R6 src", 1, 8'hA5);
        read_reg("R4 other", 3, 8'hF0);
    endtask

    task automatic t_bus_priority();
        idle();
        lit_sel = 1'b1; bus_lit = 8'h5A; dr_ld = 1'b1;
        step();
        check("R8 dr from bus", dr_q, 8'h5A);
        dr_sel = 1'b1; src_sel = 2'd3;
        #1;
        check("R3 dr on bus", bus_q, 8'h5A);
        lit_sel = 1'b1; bus_lit = 8'hC3;
        #1;
        check("R3 lit priority", bus_q, 8'hC3);
    endtask

    task automatic t_memory();
        idle();
        lit_sel = 1'b1; bus_lit = 8'h35; ar_ld = 1'b1;
        step();
        check("R7 ar load", {4'h0, ar_q}, 8'h05);
        lit_sel = 1'b1; bus_lit = 8'h77; dr_ld = 1'b1;
        step();
        check("R7 ar hold", {4'h0, ar_q}, 8'h05);
        mem_wr = 1'b1;
        lit_sel = 1'b1; bus_lit = 8'h96; ar_ld = 1'b1; dr_ld = 1'b1;
        dst_en = 1'b1; dst_sel = 2'd0;
        step();
        check("R9 ar after", {4'h0, ar_q}, 8'h06);
        check("R9 dr after", dr_q, 8'h96);
        read_reg("R9 reg load", 0, 8'h96);
        mem_wr = 1'b1;
        step();
        lit_sel = 1'b1; bus_lit = 8'h05; ar_ld = 1'b1;
        step();
        mem_rd = 1'b1;
        step();
        check("R9 old word", dr_q, 8'h77);
        mem_rd = 1'b1; dr_ld = 1'b1; lit_sel = 1'b1; bus_lit = 8'h11;
        step();
        check("R8 read priority", dr_q, 8'h77);
        lit_sel = 1'b1; bus_lit = 8'h06; ar_ld = 1'b1;
        step();
        mem_rd = 1'b1;
        step();
        check("R10 other word", dr_q, 8'h96);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_all();
        t_disabled();
        t_reg_xfer();
        t_bus_priority();
        t_memory();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule